// File: doc/BRIEF.md
# LCD Bias Power-Up Sequencer

This block is the digital controller that brings up and tears down the rails of a display bias supply. It watches a handful of flags from the analog side: enable, input undervoltage, reference good, boost in regulation, bypass-switch node low, delay-capacitor threshold, boost current limit and over-temperature. From these it raises, in a fixed order, the enable and soft-start requests for the reference, the bypass-switch pull-down, the boost, the negative pump, and then the positive pump together with its supply isolation switch. All durations are counted in ticks of a prescaled clock. A separate qualifier drives the external isolation gate low once the boost has stayed regulated for a full delay window, and holds it there until the sequencer shuts down.

The sequencer walks these states: IDLE (0), REF_SS (1), BSW_WAIT (2), BOOST_SS (3), NEG_WAIT (4), NEG_SS (5), DUAL_SS (6), POS_DLY (7), ISO_SS (8), RUN (9), OTP_HOLD (10) and LOCKOUT (11). The normal transitions are IDLE to REF_SS on start, REF_SS to BSW_WAIT on reference good, and BSW_WAIT to BOOST_SS on bypass low. When the delay-capacitor threshold is already crossed at that point, BSW_WAIT goes to DUAL_SS instead. BOOST_SS goes to NEG_WAIT after a soft-start, and NEG_WAIT goes to NEG_SS on regulation with threshold. NEG_SS or DUAL_SS goes to POS_DLY after a soft-start, POS_DLY goes to ISO_SS after the rest of the delay window, and ISO_SS goes to RUN after a soft-start. Three transitions come from faults or shutdown. Any state goes to IDLE on shutdown. A boost-phase state goes to LOCKOUT on current limit. An active state goes to OTP_HOLD on over-temperature, and OTP_HOLD returns to REF_SS when the over-temperature flag clears. The parameter T_DLY must exceed T_SS.

Top module: `lcd_bias_sequencer`

## Requirements
- R1: The block leaves IDLE for REF_SS only at a clock edge where en_i is 1 and uvlo_i is 0, and ref_en_o is 1 in every state except IDLE and LOCKOUT.
- R2: REF_SS moves to BSW_WAIT only when ref_ok_i is 1. bsw_pd_o is 1 from BSW_WAIT through RUN. BSW_WAIT holds with boost_en_o at 0 until bsw_low_i is 1.
- R3: BOOST_SS drives boost_en_o and boost_ss_o to 1 and lasts PRESCALE*T_SS+1 clock cycles. It then enters NEG_WAIT with boost_ss_o at 0.
- R4: NEG_WAIT enters NEG_SS, with neg_en_o and neg_ss_o at 1, only when boost_reg_i and cdly_hi_i are both 1.
- R5: If cdly_hi_i is 1 when bsw_low_i releases BSW_WAIT, the block enters DUAL_SS. In DUAL_SS the boost and negative pump enables and soft-starts are all 1 for PRESCALE*T_SS+1 cycles, after which the block enters POS_DLY.
- R6: NEG_SS lasts PRESCALE*T_SS+1 cycles and is followed by POS_DLY. POS_DLY keeps the negative pump on and the positive pump off for PRESCALE*(T_DLY-T_SS)+1 cycles.
- R7: ISO_SS drives pos_en_o, pos_ss_o, iso_en_o and iso_ss_o to 1 for PRESCALE*T_SS+1 cycles. It is followed by RUN, where every enable is 1 and every soft-start is 0.
- R8: ps_low_o becomes 1 after boost_reg_i has been 1, with the boost enabled, for PRESCALE*T_DLY consecutive clock edges. Any cycle with boost_reg_i at 0 before that point restarts the count.
- R9: Once set, ps_low_o stays 1 whatever boost_reg_i does, until the block reaches IDLE, LOCKOUT or OTP_HOLD. It clears one cycle after entering one of those states.
- R10: en_i at 0 or uvlo_i at 1 in any state sends the block to IDLE at the next edge, with every enable and fault_o at 0.
- R11: ilim_i at 1 while the boost is enabled sends the block to LOCKOUT at the next edge. In LOCKOUT fault_o is 1 and every enable, including the isolation switch and the bypass pull-down, is 0. The block leaves LOCKOUT only to IDLE, on en_i low or uvlo_i high. ilim_i has no effect in IDLE.
- R12: otp_i at 1 in any state from REF_SS to RUN sends the block to OTP_HOLD. In OTP_HOLD only ref_en_o and fault_o are 1. When otp_i clears, the block returns to REF_SS and goes through the soft-starts again.
- R13: state_o reports the state in the 4-bit codes listed above, and reset puts the block in IDLE with all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencing enable |
| uvlo_i | input | 1 | Input supply below undervoltage threshold |
| ref_ok_i | input | 1 | Reference within its window |
| boost_reg_i | input | 1 | Boost output within its regulation window |
| bsw_low_i | input | 1 | Bypass-switch node below threshold |
| cdly_hi_i | input | 1 | Delay-capacitor node above threshold |
| ilim_i | input | 1 | Boost switch current limit hit |
| otp_i | input | 1 | Over-temperature flag |
| ref_en_o | output | 1 | Reference enable |
| bsw_pd_o | output | 1 | Bypass-switch pull-down request |
| boost_en_o | output | 1 | Boost enable |
| boost_ss_o | output | 1 | Boost soft-start active |
| neg_en_o | output | 1 | Negative pump enable |
| neg_ss_o | output | 1 | Negative pump soft-start active |
| pos_en_o | output | 1 | Positive pump enable |
| pos_ss_o | output | 1 | Positive pump soft-start active |
| iso_en_o | output | 1 | Isolation switch enable |
| iso_ss_o | output | 1 | Isolation switch soft turn-on active |
| ps_low_o | output | 1 | Isolation gate pulled low (1) or released |
| fault_o | output | 1 | Current-limit or over-temperature shutdown |
| state_o | output | 4 | Sequencer state code |

## Verification
The assertions assume that the flag inputs are synchronous to clk and already debounced. They take for granted that a flag changes at most once per edge and that reset is held across at least one edge. The ordering properties also assume that shutdown has priority: when en_i is low or uvlo_i is high, no property expects a fault state. The bench changes every input only on the falling edge. It sweeps each shutdown and fault source against every later sequence state in turn, and between scenarios it returns to IDLE by dropping en_i.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 4'd0,
        ST_REF_SS   = 4'd1,
        ST_BSW_WAIT = 4'd2,
        ST_BOOST_SS = 4'd3,
        ST_NEG_WAIT = 4'd4,
        ST_NEG_SS   = 4'd5,
        ST_DUAL_SS  = 4'd6,
        ST_POS_DLY  = 4'd7,
        ST_ISO_SS   = 4'd8,
        ST_RUN      = 4'd9,
        ST_OTP_HOLD = 4'd10,
        ST_LOCKOUT  = 4'd11
    } lbs_state_e;

    // Boost switch is active in these states.
    function automatic logic in_boost_phase(lbs_state_e s);
        return (s == ST_BOOST_SS) || (s == ST_NEG_WAIT) || (s == ST_NEG_SS) ||
               (s == ST_DUAL_SS)  || (s == ST_POS_DLY)  || (s == ST_ISO_SS) ||
               (s == ST_RUN);
    endfunction

    // Active sequencing states (over-temperature can interrupt these).
    function automatic logic in_seq_phase(lbs_state_e s);
        return (s == ST_REF_SS) || (s == ST_BSW_WAIT) || in_boost_phase(s);
    endfunction

    // States in which the gate qualifier is cleared.
    function automatic logic in_rest_state(lbs_state_e s);
        return (s == ST_IDLE) || (s == ST_LOCKOUT) || (s == ST_OTP_HOLD);
    endfunction

endpackage

// File: rtl/lbs_prescaler.sv
module lbs_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (pcnt_q == LAST) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign tick_o = (pcnt_q == LAST) && !clr;

endmodule

// File: rtl/lbs_tick_timer.sv
module lbs_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q >= limit);

endmodule

// File: rtl/lbs_ps_qualifier.sv
module lbs_ps_qualifier #(
    parameter int DIV = 2,
    parameter int WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic boost_on,
    input  logic in_window,
    output logic ps_low_o
);
    localparam int QW = $clog2(WIN + 1);
    localparam logic [QW-1:0] LAST = QW'(WIN - 1);

    logic          qual;
    logic          held_q;
    logic [QW-1:0] qcnt_q;
    logic          qtick;

    assign qual = boost_on && in_window && !held_q && !clr;

    lbs_prescaler #(.DIV(DIV)) u_qdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!qual),
        .tick_o (qtick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            qcnt_q <= '0;
        end else if (clr) begin
            held_q <= 1'b0;
            qcnt_q <= '0;
        end else if (!held_q) begin
            if (!qual) begin
                qcnt_q <= '0;
            end else if (qtick) begin
                if (qcnt_q == LAST) begin
                    held_q <= 1'b1;
                end else begin
                    qcnt_q <= qcnt_q + 1'b1;
                end
            end
        end
    end

    assign ps_low_o = held_q;

endmodule

// File: rtl/lcd_bias_sequencer.sv
module lcd_bias_sequencer
    import lbs_pkg::*;
#(
    parameter int PRESCALE = 50,
    parameter int T_SS     = 20,
    parameter int T_DLY    = 150
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               uvlo_i,
    input  logic               ref_ok_i,
    input  logic               boost_reg_i,
    input  logic               bsw_low_i,
    input  logic               cdly_hi_i,
    input  logic               ilim_i,
    input  logic               otp_i,
    output logic               ref_en_o,
    output logic               bsw_pd_o,
    output logic               boost_en_o,
    output logic               boost_ss_o,
    output logic               neg_en_o,
    output logic               neg_ss_o,
    output logic               pos_en_o,
    output logic               pos_ss_o,
    output logic               iso_en_o,
    output logic               iso_ss_o,
    output logic               ps_low_o,
    output logic               fault_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int TCW = $clog2(T_DLY + 1);
    localparam logic [TCW-1:0] SS_LIM  = TCW'(T_SS);
    localparam logic [TCW-1:0] GAP_LIM = TCW'(T_DLY - T_SS);

    lbs_state_e state_q, state_d;

    logic run_ok;
    logic tmr_clr;
    logic tmr_tick;
    logic tmr_done;
    logic [TCW-1:0] tmr_lim;

    assign run_ok = en_i && !uvlo_i;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if ((state_q != ST_IDLE) && !run_ok) begin
            state_d = ST_IDLE;
        end else if (ilim_i && in_boost_phase(state_q)) begin
            state_d = ST_LOCKOUT;
        end else if (otp_i && in_seq_phase(state_q)) begin
            state_d = ST_OTP_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (run_ok) state_d = ST_REF_SS;
                end
                ST_REF_SS: begin
                    if (ref_ok_i) state_d = ST_BSW_WAIT;
                end
                ST_BSW_WAIT: begin
                    if (bsw_low_i) begin
                        state_d = cdly_hi_i ? ST_DUAL_SS : ST_BOOST_SS;
                    end
                end
                ST_BOOST_SS: begin
                    if (tmr_done) state_d = ST_NEG_WAIT;
                end
                ST_NEG_WAIT: begin
                    if (boost_reg_i && cdly_hi_i) state_d = ST_NEG_SS;
                end
                ST_NEG_SS, ST_DUAL_SS: begin
                    if (tmr_done) state_d = ST_POS_DLY;
                end
                ST_POS_DLY: begin
                    if (tmr_done) state_d = ST_ISO_SS;
                end
                ST_ISO_SS: begin
                    if (tmr_done) state_d = ST_RUN;
                end
                ST_RUN: begin
                    state_d = ST_RUN;
                end
                ST_OTP_HOLD: begin
                    if (!otp_i) state_d = ST_REF_SS;
                end
                ST_LOCKOUT: begin
                    state_d = ST_LOCKOUT;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // ---------------- state timer ----------------
    assign tmr_clr = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_BOOST_SS, ST_NEG_SS, ST_DUAL_SS, ST_ISO_SS: tmr_lim = SS_LIM;
            ST_POS_DLY:                                    tmr_lim = GAP_LIM;
            default:                                       tmr_lim = '0;
        endcase
    end

    lbs_prescaler #(.DIV(PRESCALE)) u_tdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick_o (tmr_tick)
    );

    lbs_tick_timer #(.CW(TCW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tmr_tick),
        .limit  (tmr_lim),
        .done_o (tmr_done)
    );

    // ---------------- outputs ----------------
    always_comb begin
        ref_en_o   = 1'b0;
        bsw_pd_o   = 1'b0;
        boost_en_o = 1'b0;
        boost_ss_o = 1'b0;
        neg_en_o   = 1'b0;
        neg_ss_o   = 1'b0;
        pos_en_o   = 1'b0;
        pos_ss_o   = 1'b0;
        iso_en_o   = 1'b0;
        iso_ss_o   = 1'b0;
        fault_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_REF_SS: begin
                ref_en_o = 1'b1;
            end
            ST_BSW_WAIT: begin
                ref_en_o = 1'b1;
                bsw_pd_o = 1'b1;
            end
            ST_BOOST_SS: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                boost_ss_o = 1'b1;
            end
            ST_NEG_WAIT: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
            end
            ST_NEG_SS: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                neg_en_o   = 1'b1;
                neg_ss_o   = 1'b1;
            end
            ST_DUAL_SS: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                boost_ss_o = 1'b1;
                neg_en_o   = 1'b1;
                neg_ss_o   = 1'b1;
            end
            ST_POS_DLY: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                neg_en_o   = 1'b1;
            end
            ST_ISO_SS: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                neg_en_o   = 1'b1;
                pos_en_o   = 1'b1;
                pos_ss_o   = 1'b1;
                iso_en_o   = 1'b1;
                iso_ss_o   = 1'b1;
            end
            ST_RUN: begin
                ref_en_o   = 1'b1;
                bsw_pd_o   = 1'b1;
                boost_en_o = 1'b1;
                neg_en_o   = 1'b1;
                pos_en_o   = 1'b1;
                iso_en_o   = 1'b1;
            end
            ST_OTP_HOLD: begin
                ref_en_o = 1'b1;
                fault_o  = 1'b1;
            end
            ST_LOCKOUT: begin
                fault_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // ---------------- isolation gate qualifier ----------------
    lbs_ps_qualifier #(.DIV(PRESCALE), .WIN(T_DLY)) u_psq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (in_rest_state(state_q)),
        .boost_on  (boost_en_o),
        .in_window (boost_reg_i),
        .ps_low_o  (ps_low_o)
    );

    assign state_o = state_q;

endmodule

// File: rtl/lbs_sva.sv
module lbs_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       uvlo_i,
    input logic       boost_reg_i,
    input logic       ilim_i,
    input logic       otp_i,
    input logic       ref_en_o,
    input logic       bsw_pd_o,
    input logic       boost_en_o,
    input logic       neg_en_o,
    input logic       pos_en_o,
    input logic       iso_en_o,
    input logic       ps_low_o,
    input logic       fault_o,
    input logic [3:0] state_o
);
    // R1
    ref_start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en_o) |-> $past(en_i && !uvlo_i));

    // R2
    boost_after_pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en_o) |-> $past(bsw_pd_o));

    // R6
    pos_after_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_en_o) |-> $past(neg_en_o));

    // R8
    ps_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps_low_o) |-> $past(boost_reg_i));

    // R9
    ps_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_low_o && ref_en_o && !fault_o && en_i && !uvlo_i && !ilim_i && !otp_i)
        |=> ps_low_o);

    // R10
    shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || uvlo_i) |=> (!ref_en_o && !boost_en_o && !fault_o));

    // R11
    ilim_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_i && boost_en_o && en_i && !uvlo_i) |=> (!iso_en_o && !bsw_pd_o && fault_o));

    // R12
    otp_stops_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_i && en_i && !uvlo_i) |=> !boost_en_o);

    // R13
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 4'd11);

endmodule

bind lcd_bias_sequencer lbs_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .uvlo_i      (uvlo_i),
    .boost_reg_i (boost_reg_i),
    .ilim_i      (ilim_i),
    .otp_i       (otp_i),
    .ref_en_o    (ref_en_o),
    .bsw_pd_o    (bsw_pd_o),
    .boost_en_o  (boost_en_o),
    .neg_en_o    (neg_en_o),
    .pos_en_o    (pos_en_o),
    .iso_en_o    (iso_en_o),
    .ps_low_o    (ps_low_o),
    .fault_o     (fault_o),
    .state_o     (state_o)
);

// File: tb/lcd_bias_sequencer_bench.sv
module lcd_bias_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 2;
    localparam int TSS  = 3;
    localparam int TDLY = 5;
    localparam int SS_CYC  = P * TSS + 1;
    localparam int GAP_CYC = P * (TDLY - TSS) + 1;
    localparam int PS_CYC  = P * TDLY;

    localparam int S_IDLE = 0, S_REF = 1, S_BSW = 2, S_BOOST = 3, S_NEGW = 4,
                   S_NEG = 5, S_DUAL = 6, S_PDLY = 7, S_ISO = 8, S_RUN = 9,
                   S_OTP = 10, S_LOCK = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i, uvlo_i, ref_ok_i, boost_reg_i, bsw_low_i, cdly_hi_i, ilim_i, otp_i;
    logic ref_en_o, bsw_pd_o, boost_en_o, boost_ss_o, neg_en_o, neg_ss_o;
    logic pos_en_o, pos_ss_o, iso_en_o, iso_ss_o, ps_low_o, fault_o;
    logic [3:0] state_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_bias_sequencer #(.PRESCALE(P), .T_SS(TSS), .T_DLY(TDLY)) u_lcd_bias_sequencer (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i), .ref_ok_i(ref_ok_i),
        .boost_reg_i(boost_reg_i), .bsw_low_i(bsw_low_i), .cdly_hi_i(cdly_hi_i),
        .ilim_i(ilim_i), .otp_i(otp_i), .ref_en_o(ref_en_o), .bsw_pd_o(bsw_pd_o),
        .boost_en_o(boost_en_o), .boost_ss_o(boost_ss_o), .neg_en_o(neg_en_o),
        .neg_ss_o(neg_ss_o), .pos_en_o(pos_en_o), .pos_ss_o(pos_ss_o),
        .iso_en_o(iso_en_o), .iso_ss_o(iso_ss_o), .ps_low_o(ps_low_o),
        .fault_o(fault_o), .state_o(state_o)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // {iso_en, pos_en, neg_en, boost_en, bsw_pd, ref_en}
    function automatic int rails();
        return int'({iso_en_o, pos_en_o, neg_en_o, boost_en_o, bsw_pd_o, ref_en_o});
    endfunction

    function automatic int softs();
        return int'({iso_ss_o, pos_ss_o, neg_ss_o, boost_ss_o});
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dwell(output int c);
        int s0;
        s0 = int'(state_o);
        c = 0;
        while (int'(state_o) == s0 && c < 1000) begin
            @(posedge clk);
            c++;
            @(negedge clk);
        end
    endtask

    task automatic wait_state(input string req, input int s);
        int n;
        n = 0;
        while (int'(state_o) != s && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk_eq(req, int'(state_o), s);
    endtask

    task automatic good_inputs();
        en_i = 1'b0; uvlo_i = 1'b0; ref_ok_i = 1'b1; boost_reg_i = 1'b1;
        bsw_low_i = 1'b1; cdly_hi_i = 1'b1; ilim_i = 1'b0; otp_i = 1'b0;
    endtask

    initial begin
        int c;
        good_inputs();
        ref_ok_i = 1'b0; bsw_low_i = 1'b0; cdly_hi_i = 1'b0; boost_reg_i = 1'b0;
        step(3);
        // R13 reset state
        chk_eq("R13 reset state", int'(state_o), S_IDLE);
        chk_eq("R13 reset rails", rails(), 0);
        chk_eq("R13 reset gate/fault", int'({ps_low_o, fault_o}), 0);
        rst_n = 1'b1;
        step(1);

        // R1 start gating
        en_i = 1'b1; uvlo_i = 1'b1;
        step(3);
        chk_eq("R1 hold under uvlo", int'(state_o), S_IDLE);
        uvlo_i = 1'b0;
        step(1);
        chk_eq("R1 start state", int'(state_o), S_REF);
        chk_eq("R1 ref enable", rails(), 1);

        // R2 reference and bypass stages
        step(3);
        chk_eq("R2 wait ref", int'(state_o), S_REF);
        ref_ok_i = 1'b1;
        step(1);
        chk_eq("R2 bsw state", int'(state_o), S_BSW);
        chk_eq("R2 pulldown no boost", rails(), 3);
        step(3);
        chk_eq("R2 wait bsw low", int'(state_o), S_BSW);
        bsw_low_i = 1'b1;
        step(1);

        // R3 boost soft-start
        chk_eq("R3 boost state", int'(state_o), S_BOOST);
        chk_eq("R3 boost rails", rails(), 7);
        chk_eq("R3 boost softs", softs(), 1);
        dwell(c);
        chk_eq("R3 boost ss length", c, SS_CYC);
        chk_eq("R3 neg wait state", int'(state_o), S_NEGW);
        chk_eq("R3 ss released", softs(), 0);

        // R4 negative pump gating
        cdly_hi_i = 1'b1; boost_reg_i = 1'b0;
        step(3);
        chk_eq("R4 needs regulation", int'(state_o), S_NEGW);
        cdly_hi_i = 1'b0; boost_reg_i = 1'b1;
        step(6);
        chk_eq("R4 needs threshold", int'(state_o), S_NEGW);
        // R8 partial window then dropout restarts the count
        chk_eq("R8 not yet latched", int'(ps_low_o), 0);
        boost_reg_i = 1'b0;
        step(1);
        boost_reg_i = 1'b1;
        c = 0;
        while (!ps_low_o && c < 1000) begin
            @(posedge clk);
            c++;
            @(negedge clk);
        end
        chk_eq("R8 qualification length", c, PS_CYC);

        cdly_hi_i = 1'b1;
        step(1);
        chk_eq("R4 neg ss state", int'(state_o), S_NEG);
        chk_eq("R4 neg softs", softs(), 2);

        // R6 negative soft-start and gap
        dwell(c);
        chk_eq("R6 neg ss length", c, SS_CYC);
        chk_eq("R6 gap state", int'(state_o), S_PDLY);
        chk_eq("R6 gap rails", rails(), 15);
        dwell(c);
        chk_eq("R6 gap length", c, GAP_CYC);

        // R7 positive pump and isolation switch
        chk_eq("R7 iso state", int'(state_o), S_ISO);
        chk_eq("R7 iso rails", rails(), 63);
        chk_eq("R7 iso softs", softs(), 12);
        dwell(c);
        chk_eq("R7 iso length", c, SS_CYC);
        chk_eq("R7 run state", int'(state_o), S_RUN);
        chk_eq("R7 run rails", rails(), 63);
        chk_eq("R7 run softs", softs(), 0);

        // R9 gate latch holds
        chk_eq("R9 gate low in run", int'(ps_low_o), 1);
        boost_reg_i = 1'b0;
        step(3);
        chk_eq("R9 gate ignores window", int'(ps_low_o), 1);
        en_i = 1'b0;
        step(1);
        chk_eq("R10 disable to idle", int'(state_o), S_IDLE);
        chk_eq("R10 disable rails", rails(), 0);
        step(1);
        chk_eq("R9 gate released", int'(ps_low_o), 0);

        // R5 early threshold: boost and negative pump together
        good_inputs();
        step(2);
        en_i = 1'b1;
        step(3);
        chk_eq("R5 dual state", int'(state_o), S_DUAL);
        chk_eq("R5 dual rails", rails(), 15);
        chk_eq("R5 dual softs", softs(), 3);
        dwell(c);
        chk_eq("R5 dual length", c, SS_CYC);
        chk_eq("R5 then gap", int'(state_o), S_PDLY);

        // R11 current limit ignored while idle
        en_i = 1'b0; ilim_i = 1'b1;
        step(3);
        chk_eq("R11 idle ignores ilim", int'({fault_o, 4'(state_o)}), S_IDLE);
        ilim_i = 1'b0;

        // Sweep: each fault source against each later state
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < 4; t++) begin
                int tgt;
                tgt = (t == 0) ? S_DUAL : (t == 1) ? S_PDLY : (t == 2) ? S_ISO : S_RUN;
                good_inputs();
                step(2);
                en_i = 1'b1;
                wait_state("R13 reach target", tgt);
                case (k)
                    0: uvlo_i = 1'b1;
                    1: en_i = 1'b0;
                    2: ilim_i = 1'b1;
                    default: otp_i = 1'b1;
                endcase
                step(1);
                if (k < 2) begin
                    chk_eq("R10 sweep idle", int'(state_o), S_IDLE);
                    chk_eq("R10 sweep rails", int'({rails(), fault_o}), 0);
                    if (k == 0) begin
                        uvlo_i = 1'b0;
                        step(1);
                        chk_eq("R1 restart after uvlo", int'(state_o), S_REF);
                    end
                end else if (k == 2) begin
                    chk_eq("R11 lockout state", int'(state_o), S_LOCK);
                    chk_eq("R11 lockout rails", rails(), 0);
                    chk_eq("R11 lockout fault", int'(fault_o), 1);
                    ilim_i = 1'b0;
                    step(3);
                    chk_eq("R11 lockout holds", int'(state_o), S_LOCK);
                    en_i = 1'b0;
                    step(1);
                    chk_eq("R11 lockout exit", int'(state_o), S_IDLE);
                end else begin
                    chk_eq("R12 otp state", int'(state_o), S_OTP);
                    chk_eq("R12 otp rails", rails(), 1);
                    chk_eq("R12 otp fault", int'(fault_o), 1);
                    step(3);
                    chk_eq("R12 otp holds", int'(state_o), S_OTP);
                    otp_i = 1'b0;
                    step(1);
                    chk_eq("R12 otp restart", int'(state_o), S_REF);
                    wait_state("R12 back to run", S_RUN);
                end
            end
        end

        summary();
    end

endmodule